// File: doc/BRIEF.md
# Programmable Interval Timer

This block is a memory-mapped interval timer for a 16-bit register bus. A 32-bit up-counter advances once per prescaled tick. It compares its value against a programmable 32-bit limit. When the count equals the limit on a tick, the counter returns to zero and the block records an expiry event. A level interrupt is raised when the expiry flag is set and interrupts are enabled. Software programs the limit and the clock divisor, then starts the timer in periodic mode or in one-shot mode. Because the bus is 16 bits wide, the limit and the live count each appear as a pair of 16-bit halves. Reading the low count half freezes a copy of the high half, so the two reads together give one coherent 32-bit value.

The mode lives in a three-state machine: ST_IDLE, ST_PERIODIC and ST_ONESHOT. Its transitions are:

- T_START_PERIODIC: a control write with bit 0 set, from any state.
- T_START_ONESHOT: a control write with bit 1 set and bit 0 clear, from any state.
- T_STOP: a control write with both mode bits clear. It leads to ST_IDLE.
- T_ONESHOT_DONE: from ST_ONESHOT to ST_IDLE, on the tick where the count equals the limit.

When a control write and a tick fall in the same cycle, the control write takes precedence.

Top module: `interval_timer`

## Requirements

- R1: After reset, every readable register reads 0 and `irq` is low. This covers control, status, both limit halves, both count halves and the divisor.
- R2: The byte offsets are:
  - 0x00: control.
  - 0x04: status.
  - 0x08: limit low half.
  - 0x0C: limit high half.
  - 0x10: count low half.
  - 0x14: count high half.
  - 0x18: divisor.

  Values written to the limit halves and to the divisor read back unchanged at their own offsets.
- R3: In periodic mode the count increments by one on each tick. On the tick where the count equals the limit, the count returns to 0 instead of incrementing. So the count after k ticks is k mod (limit+1).
- R4: The divisor register holds the divide ratio minus one, and the value 0 means divide by one. While the timer runs, a tick occurs every (divisor+1) clock cycles. The first tick falls (divisor+1) cycles after the control write.
- R5: Status bit 0 at offset 0x04 sets on every expiry, meaning a tick where the count equals the limit. Writing 1 to status bit 0 clears it. Writing 0 to status bit 0 leaves it unchanged. If an expiry and a clear fall in the same cycle, the set wins.
- R6: `irq` is high exactly when status bit 0 is set and control bit 8 (interrupt enable) is set.
- R7: One-shot mode is started by control bit 1. At its expiry, the hardware clears control bit 1 and the count returns to 0. Counting then stays halted until software writes the control register again.
- R8: Any control write zeroes the count and restarts the prescaler. Writing 0 to control stops the timer at once, and the count then stays at 0. If bits 0 and 1 are written together, periodic mode is selected.
- R9: A read of offset 0x10 captures the high half of the count in the same cycle. A later read of offset 0x14 returns that captured value, not the live high half.
- R10: Control reads return:
  - bit 0: set while in periodic mode.
  - bit 1: set while in one-shot mode.
  - bit 8: the interrupt enable.

  All other control bits read 0.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 5 | Register byte offset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| rd_en | input | 1 | Read strobe, used for the count snapshot |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from `addr` |
| irq | output | 1 | Level interrupt |

## Verification

A register write takes effect at the rising edge that samples it. `rdata` follows `addr` in the same cycle. The count therefore reflects exactly the ticks up to the last edge. The bench counts rising edges from the edge that accepted the control write. It derives the expected count from the elapsed edge count k as floor(k/(divisor+1)) mod (limit+1), held at 0 after a one-shot expiry. It expects the status flag and `irq` from the first edge where the tick count exceeds the limit. Reads and interrupt probes are pushed into a scoreboard. They are then compared one nanosecond after the falling edge at which they were driven, which is well clear of the edge that could change the result.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // register byte offsets
    localparam int OFS_CTRL   = 'h00;
    localparam int OFS_STAT   = 'h04;
    localparam int OFS_MAX_LO = 'h08;
    localparam int OFS_MAX_HI = 'h0C;
    localparam int OFS_CNT_LO = 'h10;
    localparam int OFS_CNT_HI = 'h14;
    localparam int OFS_DIV    = 'h18;

    // spacing between the halves of a split 32-bit value
    localparam int HALF_STRIDE = 4;

    // control bit positions
    localparam int CB_PERIODIC = 0;
    localparam int CB_ONESHOT  = 1;
    localparam int CB_IRQ_EN   = 8;

    // status bit position
    localparam int SB_EXPIRED  = 0;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PERIODIC = 2'd1,
        ST_ONESHOT  = 2'd2
    } tmr_state_e;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] phase_q;
    logic             phase_end;

    // ">=" keeps the divider from running away if div is lowered mid-count
    assign phase_end = (phase_q >= div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart || !run) begin
            phase_q <= '0;
        end else if (phase_end) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + DIV_W'(1);
        end
    end

    always_comb begin
        tick = run && !restart && phase_end;
    end

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ctrl_wr,
    input  logic             sel_periodic,
    input  logic             sel_oneshot,
    input  logic [CNT_W-1:0] max_val,
    output logic [CNT_W-1:0] count,
    output tmr_state_e       state,
    output logic             expire,
    output logic             running
);

    tmr_state_e       state_q, state_d, wr_target;
    logic [CNT_W-1:0] count_q;
    logic             at_max;

    assign at_max = (count_q == max_val);

    // mode requested by a control write; periodic has priority
    always_comb begin
        if (sel_periodic) begin
            wr_target = ST_PERIODIC;
        end else if (sel_oneshot) begin
            wr_target = ST_ONESHOT;
        end else begin
            wr_target = ST_IDLE;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ctrl_wr) state_d = wr_target;
            end
            ST_PERIODIC: begin
                if (ctrl_wr) state_d = wr_target;
            end
            ST_ONESHOT: begin
                if (ctrl_wr) begin
                    state_d = wr_target;
                end else if (tick && at_max) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // counter: control writes restart from zero, ticks advance or wrap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (ctrl_wr) begin
            count_q <= '0;
        end else if (tick) begin
            count_q <= at_max ? '0 : count_q + CNT_W'(1);
        end
    end

    // outputs
    always_comb begin
        state   = state_q;
        count   = count_q;
        running = (state_q != ST_IDLE);
        expire  = tick && at_max;
    end

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int BUS_W  = 16,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    output logic              irq,
    input  tmr_state_e        state,
    input  logic [CNT_W-1:0]  count,
    input  logic              expire,
    output logic              ctrl_wr,
    output logic              sel_periodic,
    output logic              sel_oneshot,
    output logic [CNT_W-1:0]  max_val,
    output logic [BUS_W-1:0]  div_val
);

    localparam int NHALF = CNT_W / BUS_W;
    localparam int SHD_W = CNT_W - BUS_W;

    logic             irq_en_q;
    logic             status_q;
    logic [SHD_W-1:0] shadow_q;
    logic [BUS_W-1:0] div_q;
    logic [BUS_W-1:0] ctrl_view;
    logic             stat_clr;

    assign ctrl_wr      = wr_en && (addr == ADDR_W'(OFS_CTRL));
    assign sel_periodic = wdata[CB_PERIODIC];
    assign sel_oneshot  = wdata[CB_ONESHOT];
    assign stat_clr     = wr_en && (addr == ADDR_W'(OFS_STAT)) && wdata[SB_EXPIRED];

    // limit halves, one register per bus-wide slice
    for (genvar h = 0; h < NHALF; h++) begin : g_max
        logic [BUS_W-1:0] half_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                half_q <= '0;
            end else if (wr_en && (addr == ADDR_W'(OFS_MAX_LO + HALF_STRIDE * h))) begin
                half_q <= wdata;
            end
        end
        assign max_val[h*BUS_W +: BUS_W] = half_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (wr_en && (addr == ADDR_W'(OFS_DIV))) begin
            div_q <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_en_q <= 1'b0;
        end else if (ctrl_wr) begin
            irq_en_q <= wdata[CB_IRQ_EN];
        end
    end

    // expiry flag: a new event beats a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= 1'b0;
        end else if (expire) begin
            status_q <= 1'b1;
        end else if (stat_clr) begin
            status_q <= 1'b0;
        end
    end

    // upper count half frozen by a low-half read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (rd_en && (addr == ADDR_W'(OFS_CNT_LO))) begin
            shadow_q <= count[CNT_W-1:BUS_W];
        end
    end

    always_comb begin
        ctrl_view              = '0;
        ctrl_view[CB_PERIODIC] = (state == ST_PERIODIC);
        ctrl_view[CB_ONESHOT]  = (state == ST_ONESHOT);
        ctrl_view[CB_IRQ_EN]   = irq_en_q;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(OFS_CTRL):   rdata = ctrl_view;
            ADDR_W'(OFS_STAT):   rdata[SB_EXPIRED] = status_q;
            ADDR_W'(OFS_MAX_LO): rdata = max_val[BUS_W-1:0];
            ADDR_W'(OFS_MAX_HI): rdata = max_val[CNT_W-1:BUS_W];
            ADDR_W'(OFS_CNT_LO): rdata = count[BUS_W-1:0];
            ADDR_W'(OFS_CNT_HI): rdata = shadow_q;
            ADDR_W'(OFS_DIV):    rdata = div_q;
            default:             rdata = '0;
        endcase
    end

    always_comb begin
        div_val = div_q;
        irq     = status_q && irq_en_q;
    end

endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int BUS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    output logic              irq
);

    localparam int CNT_W = 2 * BUS_W;

    logic             tick;
    logic             ctrl_wr;
    logic             sel_periodic;
    logic             sel_oneshot;
    logic             expire;
    logic             running;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] max_val;
    logic [BUS_W-1:0] div_val;
    tmr_state_e       state;

    tmr_regs #(
        .ADDR_W (ADDR_W),
        .BUS_W  (BUS_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr         (addr),
        .wr_en        (wr_en),
        .rd_en        (rd_en),
        .wdata        (wdata),
        .rdata        (rdata),
        .irq          (irq),
        .state        (state),
        .count        (count),
        .expire       (expire),
        .ctrl_wr      (ctrl_wr),
        .sel_periodic (sel_periodic),
        .sel_oneshot  (sel_oneshot),
        .max_val      (max_val),
        .div_val      (div_val)
    );

    tmr_prescaler #(
        .DIV_W (BUS_W)
    ) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (running),
        .restart (ctrl_wr),
        .div     (div_val),
        .tick    (tick)
    );

    tmr_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .ctrl_wr      (ctrl_wr),
        .sel_periodic (sel_periodic),
        .sel_oneshot  (sel_oneshot),
        .max_val      (max_val),
        .count        (count),
        .state        (state),
        .expire       (expire),
        .running      (running)
    );

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             ctrl_wr,
    input logic [1:0]       ctrl_mode,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] max_val,
    input tmr_state_e       state
);

    // R3: a tick at the limit wraps the counter to zero
    p_wrap_to_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_wr && tick && count == max_val) |=> (count == '0));

    // R3: a tick below the limit advances by exactly one
    p_step_by_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_wr && tick && count != max_val) |=> (count == $past(count) + CNT_W'(1)));

    // R4: without a tick the counter holds
    p_hold_between_ticks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_wr && !tick) |=> $stable(count));

    // R7: a one-shot run ends in idle at its expiry
    p_oneshot_halts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_wr && state == ST_ONESHOT && tick && count == max_val) |=> (state == ST_IDLE));

    // R8: a zero mode write stops and clears
    p_stop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_mode == 2'b00) |=> (state == ST_IDLE && count == '0));

    // R8: an idle timer produces no ticks
    p_idle_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !tick);

endmodule

bind interval_timer tmr_checker #(.CNT_W(CNT_W)) u_tmr_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .ctrl_wr   (ctrl_wr),
    .ctrl_mode (wdata[1:0]),
    .count     (count),
    .max_val   (max_val),
    .state     (state)
);

// File: tb/test_interval_timer.sv
module test_interval_timer;

    localparam logic [4:0] A_CTRL   = 5'h00;
    localparam logic [4:0] A_STAT   = 5'h04;
    localparam logic [4:0] A_MAX_LO = 5'h08;
    localparam logic [4:0] A_MAX_HI = 5'h0C;
    localparam logic [4:0] A_CNT_LO = 5'h10;
    localparam logic [4:0] A_CNT_HI = 5'h14;
    localparam logic [4:0] A_DIV    = 5'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;
    logic        probe_irq = 1'b0;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    // reference parameters for the expected-value model
    int m_div = 0;
    int m_max = 0;
    bit m_oneshot = 1'b0;
    bit m_irqen = 1'b0;
    int t_start = 0;

    typedef struct {
        logic        is_irq;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];

    interval_timer i_interval_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // count after k edges since the control write
    function automatic logic [31:0] model_count(int k);
        int t;
        t = k / (m_div + 1);
        if (m_oneshot && t > m_max) return 32'd0;
        return 32'(t % (m_max + 1));
    endfunction

    function automatic logic model_irq(int k);
        int t;
        t = k / (m_div + 1);
        return m_irqen && (t > m_max);
    endfunction

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [4:0] a, logic [15:0] d);
        @(negedge clk);
        addr = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == A_CTRL) t_start = cyc;
    endtask

    task automatic rd(logic [4:0] a, logic [15:0] exp, string tag);
        item_t it;
        @(negedge clk);
        addr = a;
        rd_en = 1'b1;
        it.is_irq = 1'b0;
        it.exp = exp;
        it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_cnt(string tag);
        item_t it;
        logic [31:0] e;
        @(negedge clk);
        e = model_count(cyc - t_start);
        addr = A_CNT_LO;
        rd_en = 1'b1;
        it.is_irq = 1'b0;
        it.exp = e[15:0];
        it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk_irq(logic exp, string tag);
        item_t it;
        @(negedge clk);
        probe_irq = 1'b1;
        it.is_irq = 1'b1;
        it.exp = {15'd0, exp};
        it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        probe_irq = 1'b0;
    endtask

    task automatic chk_irq_model(string tag);
        item_t it;
        @(negedge clk);
        probe_irq = 1'b1;
        it.is_irq = 1'b1;
        it.exp = {15'd0, model_irq(cyc - t_start)};
        it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        probe_irq = 1'b0;
    endtask

    // monitor: compare each probed cycle against the head of the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rd_en || probe_irq) begin
                item_t it;
                logic [15:0] act;
                n_vec++;
                if (sb.size() == 0) begin
                    n_bad++;
                    $display("FAIL scoreboard: probe with no expected item");
                end else begin
                    it = sb.pop_front();
                    act = it.is_irq ? {15'd0, irq} : rdata;
                    if (act !== it.exp) begin
                        n_bad++;
                        $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(A_CTRL,   16'h0000, "R1 ctrl");
        rd(A_STAT,   16'h0000, "R1 status");
        rd(A_MAX_LO, 16'h0000, "R1 max lo");
        rd(A_MAX_HI, 16'h0000, "R1 max hi");
        rd(A_CNT_LO, 16'h0000, "R1 count lo");
        rd(A_CNT_HI, 16'h0000, "R1 count hi");
        rd(A_DIV,    16'h0000, "R1 divisor");
        chk_irq(1'b0, "R1 irq");

        // R2: readback of limit and divisor
        wr(A_MAX_HI, 16'hABCD);
        wr(A_MAX_LO, 16'h1234);
        wr(A_DIV,    16'h0008);
        rd(A_MAX_HI, 16'hABCD, "R2 max hi");
        rd(A_MAX_LO, 16'h1234, "R2 max lo");
        rd(A_DIV,    16'h0008, "R2 divisor");

        // R3 / R6 / R10: periodic, divide by one, limit 4, irq enabled
        wr(A_MAX_HI, 16'h0000);
        wr(A_MAX_LO, 16'h0004);
        wr(A_DIV,    16'h0000);
        m_div = 0; m_max = 4; m_oneshot = 1'b0; m_irqen = 1'b1;
        wr(A_CTRL, 16'h0101);
        chk_irq_model("R6 irq before first expiry");
        rd(A_CTRL, 16'h0101, "R10 ctrl periodic");
        rd_cnt("R3 count at wrap");
        rd_cnt("R3 count after wrap");
        chk_irq_model("R6 irq after expiry");
        rd(A_STAT, 16'h0001, "R5 status set");

        // R8 / R5 / R6: stop, status kept, clear semantics
        wr(A_CTRL, 16'h0000);
        rd(A_CTRL, 16'h0000, "R8 ctrl stopped");
        idle(5);
        rd(A_CNT_LO, 16'h0000, "R8 count held at zero");
        rd(A_STAT, 16'h0001, "R5 status survives stop");
        chk_irq(1'b0, "R6 irq masked by enable");
        wr(A_STAT, 16'h0000);
        rd(A_STAT, 16'h0001, "R5 write zero ignored");
        wr(A_STAT, 16'h0001);
        rd(A_STAT, 16'h0000, "R5 write one clears");

        // R4: divide by three, limit 3, irq disabled
        wr(A_DIV,    16'h0002);
        wr(A_MAX_LO, 16'h0003);
        m_div = 2; m_max = 3; m_oneshot = 1'b0; m_irqen = 1'b0;
        wr(A_CTRL, 16'h0001);
        rd_cnt("R4 prescaled count a");
        rd_cnt("R4 prescaled count b");
        idle(1);
        rd_cnt("R4 prescaled count c");
        rd_cnt("R4 prescaled count d");
        idle(20);
        rd(A_STAT, 16'h0001, "R5 status after prescaled wrap");
        chk_irq(1'b0, "R6 irq off while disabled");
        wr(A_CTRL, 16'h0000);
        wr(A_STAT, 16'h0001);

        // R7: one-shot, divide by one, limit 3
        wr(A_DIV, 16'h0000);
        m_div = 0; m_max = 3; m_oneshot = 1'b1; m_irqen = 1'b1;
        wr(A_CTRL, 16'h0102);
        rd(A_CTRL, 16'h0102, "R10 ctrl one-shot");
        rd_cnt("R7 one-shot counting");
        idle(4);
        rd(A_CTRL, 16'h0100, "R7 trigger bit cleared");
        rd_cnt("R7 count halted at zero");
        chk_irq_model("R7 irq after one-shot");
        rd(A_STAT, 16'h0001, "R7 status after one-shot");
        wr(A_STAT, 16'h0001);
        wr(A_CTRL, 16'h0102);
        rd_cnt("R7 retrigger counts");
        chk_irq_model("R7 irq low after retrigger");
        wr(A_CTRL, 16'h0000);
        wr(A_STAT, 16'h0001);

        // R8: both mode bits give periodic, count restarts
        m_oneshot = 1'b0; m_irqen = 1'b0;
        wr(A_CTRL, 16'h0003);
        rd(A_CTRL, 16'h0001, "R8 periodic wins");
        rd_cnt("R8 count from restart");
        idle(2);
        rd_cnt("R8 periodic continues");
        wr(A_CTRL, 16'h0000);
        wr(A_STAT, 16'h0001);

        // R9: coherent snapshot across the 16-bit boundary
        wr(A_MAX_HI, 16'h0002);
        wr(A_MAX_LO, 16'h0000);
        m_div = 0; m_max = 32'h0002_0000; m_oneshot = 1'b0;
        wr(A_CTRL, 16'h0001);
        while (cyc < t_start + 65534) @(negedge clk);
        rd_cnt("R9 low half at 0xFFFF");
        rd(A_CNT_HI, 16'h0000, "R9 high half from snapshot");
        rd_cnt("R3 low half past boundary");
        rd(A_CNT_HI, 16'h0001, "R9 high half after carry");
        wr(A_CTRL, 16'h0000);

        idle(3);
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: %0d items never compared", sb.size());
        end
        finish_up();
    end

endmodule